// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a field-configurable two-level logic array. Sixteen input variables feed forty-eight product terms (the AND plane), and those terms feed eight independent outputs through a second programmable plane (the OR plane). Every crossover point in both planes is one bit in a configuration store. A stored 0 keeps the link and a stored 1 removes it.

Software, or a boot sequencer, loads the store one product term per clock through a simple write port. The port carries a term index, the term's 32 AND-plane bits and its 8 OR-plane bits. Once the store is loaded, the eight outputs follow the inputs combinationally, with no clock in the path. Reset returns every bit to 0. That is the unprogrammed state: each term then sees both a variable and its inverse, so every output reads 0.

Top module: `sop_logic_array`

## Requirements
- R1: While synchronous active-low reset is applied, every configuration bit is cleared to 0. From then until the first accepted write, all eight outputs are 0 for any input pattern.
- R2: A write is accepted on a rising clock edge when `cfg_we` is 1 and `cfg_term` is below 48. It replaces that term's 32 AND-plane bits and 8 OR-plane bits, and the outputs reflect the new contents from that edge on. The other terms keep their contents.
- R3: A write whose `cfg_term` is 48 or above changes nothing in the store, so the outputs stay the same for the same inputs.
- R4: In `cfg_and`, bit 2i is the removal bit of the true link of input i, and bit 2i+1 is the removal bit of the inverse link of input i. A bit value of 0 keeps the link.
- R5: An input whose true and inverse links are both kept forces its term to 0.
- R6: When only the true link is kept, the term includes input i. When only the inverse link is kept, the term includes the complement of input i.
- R7: When both links are removed, the input does not affect the term. A term with every link removed evaluates to 1.
- R8: In `cfg_or`, bit k is the removal bit of the link from this term to output k (0 keeps it). Output k is the OR of the terms linked to it, and an output with no linked term is 0.
- R9: One product term may be linked to several outputs at once and drives each of them.
- R10: Outputs follow input changes combinationally, within the same clock cycle and without a clock edge.
- R11: While no write is accepted, the configuration is held, so the outputs depend only on the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Synchronous active-low reset; clears the store |
| cfg_we | input | 1 | Write strobe for one product term |
| cfg_term | input | 6 | Index of the product term being written |
| cfg_and | input | 32 | Removal bits of the AND plane for the indexed term (bit 2i true, bit 2i+1 inverse) |
| cfg_or | input | 8 | Removal bits of the OR plane for the indexed term (bit k for output k) |
| in_vars | input | 16 | Input variables |
| out_funcs | output | 8 | Sum-of-products outputs |

## Verification
The bench programs f1 = A·B·C and f2 = A·B + B·C and sweeps all 65536 input patterns. A design that swapped the true and inverse bits, or misread one of them, would fail on the complemented patterns. The unprogrammed both-links-kept case and the all-links-removed case are both checked. A design that treated an unprogrammed term as a don't-care would drive outputs high straight after reset, and one that treated an empty term as 0 would lose constant-1 outputs. Writes to indices 48 through 63 are checked for no effect, since a truncating index decode would alias them onto low terms. Random configurations and rewrites check that a term can be shared across outputs and that an output with no links stays 0.

// File: rtl/sop_pkg.sv
// Package: shared constants and the literal-selection cell of the array.
// Assumes: removal bits are stored as {inverse_removed, true_removed}.
package sop_pkg;

    // Default geometry of the array.
    localparam int unsigned DEF_N_IN   = 16;
    localparam int unsigned DEF_N_TERM = 48;
    localparam int unsigned DEF_N_OUT  = 8;

    // Per-crossover literal condition, bit 1 = inverse link removed,
    // bit 0 = true link removed.
    typedef enum logic [1:0] {
        LIT_BOTH_KEPT = 2'b00,
        LIT_TRUE_ONLY = 2'b10,
        LIT_INV_ONLY  = 2'b01,
        LIT_DONT_CARE = 2'b11
    } lit_sel_e;

    // Value a single input contributes to its product term.
    function automatic logic lit_value(input lit_sel_e sel, input logic x);
        logic v;
        case (sel)
            LIT_BOTH_KEPT: v = x & ~x;
            LIT_TRUE_ONLY: v = x;
            LIT_INV_ONLY:  v = ~x;
            LIT_DONT_CARE: v = 1'b1;
            default:       v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/sop_cfg_store.sv
// Module: configuration store of the array, one row per product term.
// Each row holds the AND-plane removal bits and the OR-plane removal bits.
// Assumes: a row is written only when the index matches its position
// exactly, so indices outside the term range write no row.
module sop_cfg_store #(
    parameter int unsigned N_IN   = 16,
    parameter int unsigned N_TERM = 48,
    parameter int unsigned N_OUT  = 8,
    parameter int unsigned TW     = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [TW-1:0]                        wr_term,
    input  logic [2*N_IN-1:0]                    wr_and,
    input  logic [N_OUT-1:0]                     wr_or,
    output logic [N_TERM-1:0][2*N_IN-1:0]        and_map,
    output logic [N_TERM-1:0][N_OUT-1:0]         or_map
);

    localparam int unsigned AW = 2 * N_IN;

    for (genvar t = 0; t < N_TERM; t++) begin : g_row
        logic           row_sel;
        logic [AW-1:0]  and_q;
        logic [N_OUT-1:0] or_q;

        // Row select: exact index match with an active write strobe.
        assign row_sel = wr_en && (wr_term == TW'(t));

        // Row register: cleared by reset, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                and_q <= '0;
                or_q  <= '0;
            end else if (row_sel) begin
                and_q <= wr_and;
                or_q  <= wr_or;
            end
        end

        assign and_map[t] = and_q;
        assign or_map[t]  = or_q;
    end

endmodule

// File: rtl/sop_and_plane.sv
// Module: AND plane; forms every product term from the inputs.
// Assumes: and_map row t packs input i's removal bits at [2i+1:2i].
module sop_and_plane #(
    parameter int unsigned N_IN   = 16,
    parameter int unsigned N_TERM = 48
) (
    input  logic [N_IN-1:0]                  in_vars,
    input  logic [N_TERM-1:0][2*N_IN-1:0]    and_map,
    output logic [N_TERM-1:0]                terms
);
    import sop_pkg::*;

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] lits;

        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            // Literal cell: decode the two removal bits for input i.
            always_comb begin
                lits[i] = lit_value(lit_sel_e'(and_map[t][2*i +: 2]), in_vars[i]);
            end
        end

        // Product: AND of all literal contributions.
        assign terms[t] = &lits;
    end

endmodule

// File: rtl/sop_or_plane.sv
// Module: OR plane; each output sums the product terms linked to it.
// Assumes: or_map row t bit k = 1 removes the link from term t to output k.
module sop_or_plane #(
    parameter int unsigned N_TERM = 48,
    parameter int unsigned N_OUT  = 8
) (
    input  logic [N_TERM-1:0]                terms,
    input  logic [N_TERM-1:0][N_OUT-1:0]     or_map,
    output logic [N_OUT-1:0]                 out_funcs
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        logic [N_TERM-1:0] linked;

        for (genvar t = 0; t < N_TERM; t++) begin : g_link
            // Crossover: pass the term only if its link is kept.
            assign linked[t] = terms[t] & ~or_map[t][k];
        end

        // Sum: OR of linked terms, 0 when none is linked.
        assign out_funcs[k] = |linked;
    end

endmodule

// File: rtl/sop_logic_array.sv
// Module: top of the configurable sum-of-products array.
// Holds the configuration store and evaluates both planes combinationally.
// Assumes: synchronous active-low reset; the store is loaded before use.
module sop_logic_array #(
    parameter int unsigned N_IN   = sop_pkg::DEF_N_IN,
    parameter int unsigned N_TERM = sop_pkg::DEF_N_TERM,
    parameter int unsigned N_OUT  = sop_pkg::DEF_N_OUT,
    localparam int unsigned TW    = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [TW-1:0]        cfg_term,
    input  logic [2*N_IN-1:0]    cfg_and,
    input  logic [N_OUT-1:0]     cfg_or,
    input  logic [N_IN-1:0]      in_vars,
    output logic [N_OUT-1:0]     out_funcs
);

    logic [N_TERM-1:0][2*N_IN-1:0] and_map;
    logic [N_TERM-1:0][N_OUT-1:0]  or_map;
    logic [N_TERM-1:0]             terms;

    sop_cfg_store #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT),
        .TW     (TW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_term (cfg_term),
        .wr_and  (cfg_and),
        .wr_or   (cfg_or),
        .and_map (and_map),
        .or_map  (or_map)
    );

    sop_and_plane #(
        .N_IN   (N_IN),
        .N_TERM (N_TERM)
    ) u_and (
        .in_vars (in_vars),
        .and_map (and_map),
        .terms   (terms)
    );

    sop_or_plane #(
        .N_TERM (N_TERM),
        .N_OUT  (N_OUT)
    ) u_or (
        .terms     (terms),
        .or_map    (or_map),
        .out_funcs (out_funcs)
    );

endmodule

// File: rtl/sop_logic_array_chk.sv
// Module: assertion checker bound to the top; observes ports only.
// Assumes: same parameters as the top it is attached to.
module sop_logic_array_chk #(
    parameter int unsigned N_IN   = 16,
    parameter int unsigned N_TERM = 48,
    parameter int unsigned N_OUT  = 8,
    parameter int unsigned TW     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [TW-1:0]     cfg_term,
    input logic [2*N_IN-1:0] cfg_and,
    input logic [N_OUT-1:0]  cfg_or,
    input logic [N_IN-1:0]   in_vars,
    input logic [N_OUT-1:0]  out_funcs
);

    logic valid_wr;
    logic written;

    assign valid_wr = cfg_we && (int'(cfg_term) < int'(N_TERM));

    // Tracks whether any accepted write happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) written <= 1'b0;
        else if (valid_wr) written <= 1'b1;
    end

    // R1: an unprogrammed array drives all outputs low.
    a_r1_unprog_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !written |-> (out_funcs == '0));

    // R3: an out-of-range write leaves the outputs unchanged for unchanged inputs.
    a_r3_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !valid_wr) |=> (!$stable(in_vars) || $stable(out_funcs)));

    // R11: with no write, outputs depend only on the inputs.
    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> (!$stable(in_vars) || $stable(out_funcs)));

    // R7/R8: a term with all input links removed, linked to every output, forces all ones.
    a_r7_empty_term_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_wr && (&cfg_and) && (cfg_or == '0)) |=> (&out_funcs));

endmodule

bind sop_logic_array sop_logic_array_chk #(
    .N_IN   (N_IN),
    .N_TERM (N_TERM),
    .N_OUT  (N_OUT),
    .TW     (TW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_term  (cfg_term),
    .cfg_and   (cfg_and),
    .cfg_or    (cfg_or),
    .in_vars   (in_vars),
    .out_funcs (out_funcs)
);

// File: tb/sop_logic_array_tb.sv
`timescale 1ns/1ps
// Bench: directed and seeded random checks of the sum-of-products array
// against a reference model kept in bench arrays.
module sop_logic_array_tb;

    localparam int NI = 16;
    localparam int NT = 48;
    localparam int NO = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_term = '0;
    logic [31:0]   cfg_and = '0;
    logic [7:0]    cfg_or = '0;
    logic [15:0]   in_vars = '0;
    logic [7:0]    out_funcs;

    int checks = 0;
    int failures = 0;

    logic [31:0] ref_and [NT];
    logic [7:0]  ref_or  [NT];

    sop_logic_array u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_term  (cfg_term),
        .cfg_and   (cfg_and),
        .cfg_or    (cfg_or),
        .in_vars   (in_vars),
        .out_funcs (out_funcs)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Reference: evaluate the programmed model for one input pattern.
    function automatic logic [7:0] ref_eval(input logic [15:0] x);
        logic [7:0] o;
        o = '0;
        for (int t = 0; t < NT; t++) begin
            logic p;
            p = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (!ref_and[t][2*i])   p = p & x[i];
                if (!ref_and[t][2*i+1]) p = p & ~x[i];
            end
            for (int k = 0; k < NO; k++)
                if (p && !ref_or[t][k]) o[k] = 1'b1;
        end
        return o;
    endfunction

    // Random AND-plane row biased towards don't-care inputs.
    function automatic logic [31:0] rand_and_row();
        logic [31:0] r;
        for (int i = 0; i < NI; i++) begin
            int unsigned d;
            d = $urandom % 16;
            if (d < 12)       r[2*i +: 2] = 2'b11;
            else if (d < 14)  r[2*i +: 2] = 2'b10;
            else              r[2*i +: 2] = 2'b01;
        end
        if ($urandom % 16 == 0) r[2*($urandom % NI) +: 2] = 2'b00;
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s in=%h got=%h exp=%h", req, in_vars, got, exp);
        end
    endtask

    // Write one term; the reference is updated only for valid indices.
    task automatic write_term(input int t, input logic [31:0] a, input logic [7:0] o);
        @(negedge clk);
        cfg_we = 1'b1; cfg_term = 6'(t); cfg_and = a; cfg_or = o;
        @(negedge clk);
        cfg_we = 1'b0;
        if (t < NT) begin
            ref_and[t] = a;
            ref_or[t]  = o;
        end
    endtask

    task automatic clear_ref();
        for (int t = 0; t < NT; t++) begin
            ref_and[t] = '0;
            ref_or[t]  = '0;
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        clear_ref();
    endtask

    task automatic rand_compare(input string req, input int n);
        for (int j = 0; j < n; j++) begin
            in_vars = 16'($urandom);
            #1;
            check(req, out_funcs, ref_eval(in_vars));
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_ref();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: unprogrammed store gives all-zero outputs.
        for (int j = 0; j < 20; j++) begin
            in_vars = 16'($urandom);
            #1;
            check("R1 unprogrammed", out_funcs, 8'h00);
        end
        in_vars = 16'hFFFF; #1; check("R1 all ones in", out_funcs, 8'h00);
        in_vars = 16'h0000; #1; check("R1 all zero in", out_funcs, 8'h00);

        // R4 R6: f1 = A.B.C on output 0 (A=in0,B=in1,C=in2), all other inputs don't-care.
        write_term(0, {26'h3FFFFFF, 6'b10_10_10}, 8'hFE);
        // f2 = A.B + B.C on output 1.
        write_term(1, {28'hFFFFFFF, 4'b10_10}, 8'hFD);
        write_term(2, {26'h3FFFFFF, 6'b10_10_11}, 8'hFD);
        // R9: shared term ~A.~B drives outputs 2 and 3.
        write_term(3, {28'hFFFFFFF, 4'b01_01}, 8'hF3);
        // R7: empty term drives output 4 high always.
        write_term(4, 32'hFFFF_FFFF, 8'hEF);
        // R6: inverse literal of in15 on output 5.
        write_term(5, {2'b01, 30'h3FFFFFFF}, 8'hDF);

        // Exhaustive sweep of all input patterns against the model.
        for (int x = 0; x < 65536; x++) begin
            in_vars = 16'(x);
            #1;
            check("R4 R6 R9 exhaustive", out_funcs, ref_eval(in_vars));
        end
        in_vars = 16'h0007; #1; check("R6 f1 ABC=111", out_funcs[1:0], 2'b11);
        in_vars = 16'h0006; #1; check("R6 f2 BC only", out_funcs[1:0], 2'b10);
        in_vars = 16'h0000; #1; check("R9 shared term", out_funcs[3:2], 2'b11);
        in_vars = 16'h1234; #1; check("R7 empty term is 1", {7'h0, out_funcs[4]}, 8'h01);
        in_vars = 16'h8000; #1; check("R6 inverse literal", {7'h0, out_funcs[5]}, 8'h00);
        in_vars = 16'hFFFF; #1; check("R8 unlinked output 7", {7'h0, out_funcs[7]}, 8'h00);

        // R5: re-add a both-kept input to f1; term becomes 0, f1 dies.
        write_term(0, {26'h3FFFFFF, 6'b10_10_00}, 8'hFE);
        in_vars = 16'h0007; #1; check("R5 both kept forces 0", {7'h0, out_funcs[0]}, 8'h00);
        // R2: other terms unaffected by the rewrite.
        rand_compare("R2 other terms kept", 50);

        // R3: writes to indices 48..63 change nothing.
        for (int j = 0; j < 16; j++)
            write_term(48 + j, 32'hFFFF_FFFF, 8'h00);
        rand_compare("R3 bad index ignored", 100);
        in_vars = 16'h0000; #1; check("R3 no all-ones", out_funcs, ref_eval(in_vars));

        // R8: unlink term 4 from output 4; output falls to 0.
        write_term(4, 32'hFFFF_FFFF, 8'hFF);
        in_vars = 16'h0F0F; #1; check("R8 removed OR link", {7'h0, out_funcs[4]}, 8'h00);

        // Random configurations mixed with random inputs.
        for (int r = 0; r < 6; r++) begin
            for (int t = 0; t < NT; t++)
                write_term(t, rand_and_row(), 8'($urandom));
            rand_compare("R2 R8 random config", 300);
        end

        // R10: input change mid-cycle shows without a clock edge.
        @(posedge clk); #2;
        in_vars = ~in_vars; #1;
        check("R10 combinational", out_funcs, ref_eval(in_vars));

        // R11: idle cycles keep the configuration.
        repeat (50) @(negedge clk);
        rand_compare("R11 held config", 50);

        // R1: reset again clears everything.
        apply_reset();
        rand_compare("R1 after reset", 20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule